// File: doc/BRIEF.md
# Vectored Interrupt Controller with Cascade Link

This controller watches eight interrupt request lines, records which ones have fired, and signals the processor on one interrupt line whenever a recorded request deserves service. Line 0 outranks line 1, line 1 outranks line 2, and so on down to line 7. When the processor answers with an acknowledge, the controller presents an 8-bit vector on a driven data bus. The vector's upper five bits are a base fixed per instance and its lower three bits are the winning line number. The processor uses the vector to pick the handler for that source.

Requests are taken through a two-flop synchronizer and latched on their rising edge into a pending set. Acknowledging a request moves it from the pending set to an in-service set. An end-of-interrupt strobe retires the highest-priority in-service entry. A pending request raises the interrupt only when it outranks everything in service. A higher-priority line can therefore nest inside a lower one's handler, but a lower-priority line cannot.

Two instances can be chained. The slave's interrupt output feeds the master's line 2, which gives fifteen usable sources. The master is built with its cascade parameter set. When it acknowledges line 2, it drives no vector of its own and raises a cascade-acknowledge output, which serves as the slave's acknowledge input. The slave then drives its own vector.

Top module: `vic8`

## Requirements
- R1: After reset the interrupt output, the vector drive enable and the cascade-acknowledge output are all low.
- R2: A rising edge on a request line raises the interrupt output after the third rising clock edge, counting from the first edge that sees the request high. The interrupt output stays low before that edge.
- R3: When several requests are eligible, the lowest-numbered line wins. Its vector is the 5-bit base in bits 7:3 and the line number in bits 2:0.
- R4: The drive enable and the vector appear at the first clock edge that samples the acknowledge high. They stay steady while the acknowledge is held, and the enable drops at the first edge that samples the acknowledge low.
- R5: The interrupt output is high only when some pending line has a lower number than every in-service line. A request on a lower-priority line during a higher-priority handler leaves it low, and a higher-priority request during a lower-priority handler raises it.
- R6: An end-of-interrupt strobe clears only the highest-priority in-service entry. Pending lines that it was blocking then raise the interrupt output.
- R7: With the cascade parameter set, acknowledging line 2 leaves the drive enable low and raises the cascade-acknowledge output while the acknowledge is held. A slave whose acknowledge input is driven by that output drives its own vector one cycle later. Acknowledging any other line drives the master's own vector.
- R8: An acknowledge that arrives with no eligible pending request drives no vector and changes no in-service state.
- R9: A request line held high after its acknowledge is not latched again. Only a new rising edge makes it pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Request lines, bit 0 highest priority |
| inta_i | input | 1 | Processor acknowledge, held high for the vector read |
| eoi_i | input | 1 | End-of-interrupt strobe, one event per cycle high |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector: base in bits 7:3, line in bits 2:0 |
| vec_oe_o | output | 1 | Drive enable for vec_o |
| casc_ack_o | output | 1 | Acknowledge forwarded to a cascaded slave (master only) |

## Verification
Several properties are checked on every cycle: the vector drive and cascade forwarding never happen together, a drive enable always follows a sampled acknowledge, the vector holds while it is driven, a single acknowledge sets at most one in-service bit, and the interrupt output never rises without a pending request. Other behaviours need a sequence of events, so only the bench scenarios show them. These are the exact latency through the synchronizer, the priority ordering and vector values, blocking and release under nesting and end-of-interrupt, the spurious acknowledge, the held-level request, and the two-stage vector handoff from master to slave.

// File: rtl/vic8.sv
module vic8 #(
  parameter logic [4:0] VEC_BASE = 5'h08,
  parameter bit         CASCADE_MASTER = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_i,
  input  logic       inta_i,
  input  logic       eoi_i,
  output logic       intr_o,
  output logic [7:0] vec_o,
  output logic       vec_oe_o,
  output logic       casc_ack_o
);
  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam logic [LW-1:0] LINK_LINE = LW'(2);

  logic [NL-1:0] sync1_q, sync2_q, sync3_q;
  logic [NL-1:0] pend_q, isr_q;
  logic [NL-1:0] rise, mask, eligible;
  logic [NL-1:0] pend_n, isr_n;
  logic          inta_d_q, ack_start;
  logic          top_found, win_found;
  logic [LW-1:0] top_idx, win_idx;
  logic [7:0]    vec_q;
  logic          oe_q, casc_q;

  function automatic logic [LW:0] first_set(input logic [NL-1:0] v);
    logic [LW:0] r;
    r = '0;
    for (int i = NL - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, LW'(i)};
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      sync3_q <= '0;
    end else begin
      sync1_q <= irq_i;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
    end
  end

  assign rise = sync2_q & ~sync3_q;
  assign {top_found, top_idx} = first_set(isr_q);

  always_comb begin
    for (int i = 0; i < NL; i++)
      mask[i] = !top_found || (LW'(i) < top_idx);
  end

  assign eligible = pend_q & mask;
  assign {win_found, win_idx} = first_set(eligible);
  assign intr_o = win_found;
  assign ack_start = inta_i & ~inta_d_q;

  always_comb begin
    pend_n = pend_q | rise;
    isr_n  = isr_q;
    if (eoi_i && top_found) isr_n[top_idx] = 1'b0;
    if (ack_start && win_found) begin
      pend_n[win_idx] = 1'b0;
      isr_n[win_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      isr_q    <= '0;
      inta_d_q <= 1'b0;
      vec_q    <= '0;
      oe_q     <= 1'b0;
      casc_q   <= 1'b0;
    end else begin
      pend_q   <= pend_n;
      isr_q    <= isr_n;
      inta_d_q <= inta_i;
      if (!inta_i) begin
        oe_q   <= 1'b0;
        casc_q <= 1'b0;
      end else if (ack_start && win_found) begin
        if (CASCADE_MASTER && win_idx == LINK_LINE) begin
          casc_q <= 1'b1;
        end else begin
          oe_q  <= 1'b1;
          vec_q <= {VEC_BASE, win_idx};
        end
      end
    end
  end

  assign vec_o      = vec_q;
  assign vec_oe_o   = oe_q;
  assign casc_ack_o = casc_q;
endmodule

// File: rtl/vic8_chk.sv
module vic8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inta_i,
  input logic       intr_o,
  input logic [7:0] vec_o,
  input logic       vec_oe_o,
  input logic       casc_ack_o,
  input logic [7:0] pend,
  input logic [7:0] isr
);
  AST_DRIVE_XOR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n) !(vec_oe_o && casc_ack_o)); // R7
  AST_OE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n) $rose(vec_oe_o) |-> $past(inta_i)); // R4
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n) (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o)); // R4
  AST_ONE_NEW_SERVICE: assert property (@(posedge clk) disable iff (!rst_n) $countones(isr & ~$past(isr)) <= 1); // R5
  AST_INTR_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) intr_o |-> (pend != 8'h00)); // R2
endmodule

bind vic8 vic8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inta_i(inta_i), .intr_o(intr_o), .vec_o(vec_o),
  .vec_oe_o(vec_oe_o), .casc_ack_o(casc_ack_o), .pend(pend_q), .isr(isr_q)
);

// File: tb/vic8_bench.sv
module vic8_bench;
  localparam logic [4:0] BASE  = 5'h08;
  localparam logic [4:0] MBASE = 5'h04;
  localparam logic [4:0] SBASE = 5'h1A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0] irq = '0;
  logic inta = 1'b0, eoi = 1'b0;
  logic intr, oe, casc;
  logic [7:0] vec;

  vic8 #(.VEC_BASE(BASE)) u_vic8 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .inta_i(inta), .eoi_i(eoi),
    .intr_o(intr), .vec_o(vec), .vec_oe_o(oe), .casc_ack_o(casc)
  );

  logic [7:0] m_irq = '0, s_irq = '0;
  logic m_inta = 1'b0, m_eoi = 1'b0, s_eoi = 1'b0;
  logic m_intr, m_oe, m_casc, s_intr, s_oe, s_casc;
  logic [7:0] m_vec, s_vec, m_lines;
  assign m_lines = {m_irq[7:3], s_intr, m_irq[1:0]};

  vic8 #(.VEC_BASE(MBASE), .CASCADE_MASTER(1'b1)) u_mst (
    .clk(clk), .rst_n(rst_n), .irq_i(m_lines), .inta_i(m_inta), .eoi_i(m_eoi),
    .intr_o(m_intr), .vec_o(m_vec), .vec_oe_o(m_oe), .casc_ack_o(m_casc)
  );
  vic8 #(.VEC_BASE(SBASE)) u_slv (
    .clk(clk), .rst_n(rst_n), .irq_i(s_irq), .inta_i(m_casc), .eoi_i(s_eoi),
    .intr_o(s_intr), .vec_o(s_vec), .vec_oe_o(s_oe), .casc_ack_o(s_casc)
  );

  int checks = 0, fails = 0, cycles = 0;

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ack_single(input logic [2:0] line);
    inta = 1'b1;
    tick();
    check("R4 oe on ack", oe, 1);
    check("R3 vector", vec, {BASE, line});
    tick();
    check("R4 vector steady", vec, {BASE, line});
    inta = 1'b0;
    tick();
    check("R4 oe drops", oe, 0);
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1;
    tick();
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 intr idle", intr, 0);
    check("R1 oe idle", oe, 0);
    check("R1 casc idle", casc, 0);
    check("R1 master casc idle", m_casc, 0);
  endtask

  task automatic t_single();
    irq[5] = 1'b1;
    tick(2);
    check("R2 intr before latch", intr, 0);
    tick();
    check("R2 intr after sync", intr, 1);
    ack_single(3'd5);
    check("R4 intr cleared by ack", intr, 0);
    tick(5);
    check("R9 held level not relatched", intr, 0);
    irq[5] = 1'b0;
    pulse_eoi();
    tick(4);
  endtask

  task automatic t_priority();
    irq[6] = 1'b1;
    irq[1] = 1'b1;
    tick(3);
    check("R3 intr", intr, 1);
    ack_single(3'd1);
    check("R5 lower line blocked", intr, 0);
    pulse_eoi();
    check("R6 eoi releases lower", intr, 1);
    ack_single(3'd6);
    pulse_eoi();
    irq = '0;
    tick(4);
  endtask

  task automatic t_nest();
    irq[4] = 1'b1;
    tick(3);
    ack_single(3'd4);
    irq[0] = 1'b1;
    tick(3);
    check("R5 higher nests", intr, 1);
    ack_single(3'd0);
    pulse_eoi();
    irq[7] = 1'b1;
    tick(4);
    check("R5 lower blocked by line 4", intr, 0);
    pulse_eoi();
    check("R6 eoi retires line 4 only", intr, 1);
    ack_single(3'd7);
    pulse_eoi();
    irq = '0;
    tick(4);
    check("R6 all retired", intr, 0);
  endtask

  task automatic t_spurious();
    inta = 1'b1;
    tick(2);
    check("R8 no vector", oe, 0);
    inta = 1'b0;
    tick();
    irq[3] = 1'b1;
    tick(3);
    check("R8 state unchanged", intr, 1);
    ack_single(3'd3);
    pulse_eoi();
    irq = '0;
    tick(4);
  endtask

  task automatic t_cascade();
    s_irq[3] = 1'b1;
    tick(8);
    check("R7 slave reaches master", m_intr, 1);
    m_inta = 1'b1;
    tick();
    check("R7 master no vector", m_oe, 0);
    check("R7 forward ack", m_casc, 1);
    tick();
    check("R7 slave drives", s_oe, 1);
    check("R7 slave vector", s_vec, {SBASE, 3'd3});
    m_inta = 1'b0;
    tick(2);
    check("R7 forward drops", m_casc, 0);
    check("R7 slave oe drops", s_oe, 0);
    s_eoi = 1'b1;
    m_eoi = 1'b1;
    tick();
    s_eoi = 1'b0;
    m_eoi = 1'b0;
    s_irq = '0;
    m_irq[6] = 1'b1;
    tick(4);
    m_inta = 1'b1;
    tick();
    check("R7 master own vector", m_vec, {MBASE, 3'd6});
    check("R7 master oe", m_oe, 1);
    check("R7 no forward", m_casc, 0);
    m_inta = 1'b0;
    tick();
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_priority();
    t_nest();
    t_spurious();
    t_cascade();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule